// File: doc/BRIEF.md
# Reconfigurable Segment-Insertion Scan Network

This block is a scan path whose length changes at run time. It is built from segment insertion cells. Each cell holds one bit in a shift stage and one bit in an update stage. When the update bit is 1, the cell is **open** and its child segment is spliced into the path directly after the cell's own bit. When the update bit is 0, the cell is **closed** and the child segment is skipped.

The network has four cells. Two cells sit at the top level: `c0` and then `c1`.
- `c0` guards an 8-bit sensor register. The sensor register captures `sens_val` in parallel.
- `c1` is a gateway to a nested chain made of cell `c2` and then cell `c3`.
- `c2` guards a debug register with a parallel input (`dbg_in`) and a parallel output (`dbg_out`).
- `c3` guards a control register with a parallel output (`ctl_out`). The control register reads back its own update value when it captures.

An external test controller drives `sel`, `cap_en`, `shf_en` and `upd_en` as plain strobes. All of them are sampled on `clk`. An access has four steps:
1. One capture cycle.
2. As many shift cycles as the current path has bits.
3. One update cycle.
4. The new cell values then decide the path for the next access.

The serial port has no back-pressure. One bit moves on every shift cycle.

Top module: `sibnet_top`

## Requirements
- R1: After reset, every cell is closed and `dbg_out` and `ctl_out` are 0. The active path is then two bits long (`c0` then `c1`), and `scan_out` is 0.
- R2: While the path's cells stay closed, the path holds one bit per top-level cell. `scan_out` repeats `scan_in` delayed by two shift cycles.
- R3: On a capture cycle, each selected cell's shift bit loads its own open state (1 = open, 0 = closed).
- R4: On an update cycle, a selected cell's update bit loads its shift bit. At all other times the update bit keeps its value.
- R5: An open cell inserts its whole child segment between its own bit and its output. The path length becomes 1 plus the child length.
- R6: While a cell is closed, its child segment ignores capture, shift and update. The child keeps its shift contents, its parallel outputs and the state of any nested cells.
- R7: On capture, the sensor register loads `sens_val`, and its bits leave the path with bit 0 first.
- R8: On capture, the debug register loads `dbg_in`. On update, `dbg_out` takes the shifted-in value.
- R9: On update, the control register drives `ctl_out`. On capture, it reloads the current `ctl_out` so that the value can be read back.
- R10: If capture and shift are both asserted in the same cycle, capture wins and no bit moves.
- R11: While `sel` is low, every strobe is ignored.
- R12: Inside an instrument register, a bit enters at the most significant position and leaves from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; closes all cells |
| sel | input | 1 | Network selected by the test controller |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data into the path |
| scan_out | output | 1 | Serial data out of the path |
| sens_val | input | SENS_W | Sensor value captured by the sensor register |
| dbg_in | input | DBG_W | Debug register parallel input |
| dbg_out | output | DBG_W | Debug register parallel output |
| ctl_out | output | CTL_W | Control register parallel output |

## Verification
The assertions check the following on every cycle:
- A cell loads its update bit only on a selected update and holds it otherwise.
- A cell's capture loads its open state.
- Instrument update stages hold between selected updates.
- Capturing registers load their parallel inputs.
- With both top-level cells closed, `scan_out` repeats `scan_in` two shifts later.

Only the bench scenarios can show the following:
- The path length and bit order for each configuration.
- Capture taking priority over shift.
- Gating by nesting: a closed gateway shields the nested cells, and their state reappears intact when the gateway reopens.
- Strobes being ignored while `sel` is low.

// File: rtl/sibnet_pkg.sv
package sibnet_pkg;

  // Control strobes that travel down the hierarchy
  typedef struct packed {
    logic sel;
    logic cap;
    logic shf;
    logic upd;
  } scan_ctl_t;

  // Strobes seen by a child segment: selected only while the parent is open
  function automatic scan_ctl_t child_ctl(scan_ctl_t parent, logic open);
    scan_ctl_t c;
    c     = parent;
    c.sel = parent.sel & open;
    return c;
  endfunction

endpackage

// File: rtl/sib_cell.sv
module sib_cell
  import sibnet_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  scan_ctl_t ctl,
  input  logic      si,
  output logic      to_seg,
  input  logic      from_seg,
  output logic      so,
  output scan_ctl_t seg_ctl,
  output logic      is_open
);

  logic sh_q;
  logic ub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      ub_q <= 1'b0;
    end else if (ctl.sel) begin
      if (ctl.cap)      sh_q <= ub_q;
      else if (ctl.shf) sh_q <= si;
      if (ctl.upd)      ub_q <= sh_q;
    end
  end

  assign to_seg  = sh_q;
  assign so      = ub_q ? from_seg : sh_q;
  assign seg_ctl = child_ctl(ctl, ub_q);
  assign is_open = ub_q;

  AST_CELL_UPDATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && ctl.upd) |=> is_open == $past(to_seg)); // R4
  AST_CELL_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.sel && ctl.upd) |=> $stable(is_open)); // R4
  AST_CELL_CAPTURE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel && ctl.cap) |=> to_seg == $past(is_open)); // R3

endmodule

// File: rtl/instr_reg.sv
module instr_reg
  import sibnet_pkg::*;
#(
  parameter int W           = 8,
  parameter bit HAS_CAPTURE = 1'b1,
  parameter bit HAS_UPDATE  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  scan_ctl_t    ctl,
  input  logic         si,
  output logic         so,
  input  logic [W-1:0] cap_data,
  output logic [W-1:0] par_out
);

  logic [W-1:0] sh_q;
  logic [W-1:0] ur_q;
  logic [W-1:0] cap_val;

  generate
    if (HAS_UPDATE) begin : g_upd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ur_q <= '0;
        else if (ctl.sel && ctl.upd) ur_q <= sh_q;
      end
      AST_INSTR_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.sel && ctl.upd) |=> $stable(par_out)); // R6
    end else begin : g_noupd
      assign ur_q = '0;
    end
  endgenerate

  // Without a parallel input, capture reads back the update stage
  assign cap_val = HAS_CAPTURE ? cap_data : ur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (ctl.sel) begin
      if (ctl.cap)      sh_q <= cap_val;
      else if (ctl.shf) sh_q <= {si, sh_q[W-1:1]};
    end
  end

  assign so      = sh_q[0];
  assign par_out = ur_q;

  generate
    if (HAS_CAPTURE) begin : g_capchk
      AST_INSTR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sel && ctl.cap) |=> sh_q == $past(cap_data)); // R7
    end
  endgenerate

endmodule

// File: rtl/sibnet_top.sv
module sibnet_top
  import sibnet_pkg::*;
#(
  parameter int SENS_W = 8,
  parameter int DBG_W  = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [SENS_W-1:0] sens_val,
  input  logic [DBG_W-1:0]  dbg_in,
  output logic [DBG_W-1:0]  dbg_out,
  output logic [CTL_W-1:0]  ctl_out
);

  scan_ctl_t top_ctl;
  scan_ctl_t c0_seg, c1_seg, c2_seg, c3_seg;
  logic c0_to, c0_ret, c0_so, c0_open;
  logic c1_to, c1_ret, c1_so, c1_open;
  logic c2_to, c2_ret, c2_so, c2_open;
  logic c3_to, c3_ret, c3_so, c3_open;
  logic [SENS_W-1:0] sens_unused;

  assign top_ctl = '{sel: sel, cap: cap_en, shf: shf_en, upd: upd_en};

  // Top level: scan_in -> c0 -> c1 -> scan_out
  sib_cell u_c0 (
    .clk(clk), .rst_n(rst_n), .ctl(top_ctl), .si(scan_in),
    .to_seg(c0_to), .from_seg(c0_ret), .so(c0_so),
    .seg_ctl(c0_seg), .is_open(c0_open)
  );

  instr_reg #(.W(SENS_W), .HAS_CAPTURE(1'b1), .HAS_UPDATE(1'b0)) u_sens (
    .clk(clk), .rst_n(rst_n), .ctl(c0_seg), .si(c0_to), .so(c0_ret),
    .cap_data(sens_val), .par_out(sens_unused)
  );

  sib_cell u_c1 (
    .clk(clk), .rst_n(rst_n), .ctl(top_ctl), .si(c0_so),
    .to_seg(c1_to), .from_seg(c1_ret), .so(c1_so),
    .seg_ctl(c1_seg), .is_open(c1_open)
  );

  // Nested level behind c1: c2 -> c3
  sib_cell u_c2 (
    .clk(clk), .rst_n(rst_n), .ctl(c1_seg), .si(c1_to),
    .to_seg(c2_to), .from_seg(c2_ret), .so(c2_so),
    .seg_ctl(c2_seg), .is_open(c2_open)
  );

  instr_reg #(.W(DBG_W), .HAS_CAPTURE(1'b1), .HAS_UPDATE(1'b1)) u_dbg (
    .clk(clk), .rst_n(rst_n), .ctl(c2_seg), .si(c2_to), .so(c2_ret),
    .cap_data(dbg_in), .par_out(dbg_out)
  );

  sib_cell u_c3 (
    .clk(clk), .rst_n(rst_n), .ctl(c1_seg), .si(c2_so),
    .to_seg(c3_to), .from_seg(c3_ret), .so(c3_so),
    .seg_ctl(c3_seg), .is_open(c3_open)
  );

  instr_reg #(.W(CTL_W), .HAS_CAPTURE(1'b0), .HAS_UPDATE(1'b1)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl(c3_seg), .si(c3_to), .so(c3_ret),
    .cap_data({CTL_W{1'b0}}), .par_out(ctl_out)
  );

  assign c1_ret   = c3_so;
  assign scan_out = c1_so;

  logic shift_only;
  assign shift_only = sel && shf_en && !cap_en && !upd_en;

  AST_CLOSED_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_only && !c0_open && !c1_open) ##1 shift_only
      |=> scan_out == $past(scan_in, 2)); // R2

endmodule

// File: tb/sibnet_top_bench.sv
module sibnet_top_bench;
  localparam int SW = 8;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, scan_in = 1'b0;
  logic scan_out;
  logic [SW-1:0] sens_val = '0;
  logic [DW-1:0] dbg_in = '0;
  logic [DW-1:0] dbg_out;
  logic [CW-1:0] ctl_out;

  always #2 clk = ~clk; // 250 MHz

  sibnet_top #(.SENS_W(SW), .DBG_W(DW), .CTL_W(CW)) u_sibnet_top (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cap_en(cap), .shf_en(shf),
    .upd_en(upd), .scan_in(scan_in), .scan_out(scan_out),
    .sens_val(sens_val), .dbg_in(dbg_in), .dbg_out(dbg_out), .ctl_out(ctl_out)
  );

  int checks = 0;
  int failures = 0;
  logic exp_q[$];
  string tag_q[$];

  // Expected model state, kept from the requirements
  logic o0 = 0, o1 = 0, o2 = 0, o3 = 0;
  logic [DW-1:0] dbg_e = '0;
  logic [CW-1:0] ctl_e = '0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected bit per shift-only cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && sel && shf && !cap) begin
      if (exp_q.size() == 0) begin
        chk(64'(scan_out), 64'hx, "R5 unexpected shift");
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(64'(scan_out), 64'(e), t);
      end
    end
  end

  // Path image in scan_in order for the current structure
  function automatic void walk(input logic v0, v1, v2, v3, input logic [SW-1:0] vs,
                               input logic [DW-1:0] vd, input logic [CW-1:0] vc,
                               output logic [63:0] img, output int n);
    n = 0; img = '0;
    img[n] = v0; n++;
    if (o0) for (int i = SW-1; i >= 0; i--) begin img[n] = vs[i]; n++; end
    img[n] = v1; n++;
    if (o1) begin
      img[n] = v2; n++;
      if (o2) for (int i = DW-1; i >= 0; i--) begin img[n] = vd[i]; n++; end
      img[n] = v3; n++;
      if (o3) for (int i = CW-1; i >= 0; i--) begin img[n] = vc[i]; n++; end
    end
  endfunction

  task automatic access(input logic n0, n1, n2, n3, input logic [DW-1:0] nd,
                        input logic [CW-1:0] nc, input logic both, input string tag);
    logic [63:0] cimg, nimg;
    int len, len2;
    logic p1, p2, p3;
    walk(o0, o1, o2, o3, sens_val, dbg_in, ctl_e, cimg, len);
    walk(n0, n1, n2, n3, '0, nd, nc, nimg, len2);
    @(negedge clk); sel = 1; cap = 1; shf = both; upd = 0; scan_in = 1'b1;
    for (int j = 0; j < len; j++) begin
      @(negedge clk); cap = 0; shf = 1; scan_in = nimg[len-1-j];
      exp_q.push_back(cimg[len-1-j]);
      tag_q.push_back(tag);
    end
    @(negedge clk); shf = 0; upd = 1;
    @(negedge clk); upd = 0; sel = 0;
    p1 = o1; p2 = o2; p3 = o3;
    if (p1 && p2) dbg_e = nd;
    if (p1 && p3) ctl_e = nc;
    if (p1) begin o2 = n2; o3 = n3; end
    o0 = n0; o1 = n1;
    #1;
    chk(64'(dbg_out), 64'(dbg_e), {tag, " dbg_out"});
    chk(64'(ctl_out), 64'(ctl_e), {tag, " ctl_out"});
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(64'(scan_out), 0, "R1 scan_out");
    chk(64'(dbg_out), 0, "R1 dbg_out");
    chk(64'(ctl_out), 0, "R1 ctl_out");
    // R2/R3: two-bit path, open the gateway c1
    access(0, 1, 0, 0, '0, '0, 0, "R2 closed path");
    // R5: nested cells appear behind c1; open c2 and c3
    access(0, 1, 1, 1, '0, '0, 0, "R5 nested path");
    // R8/R9/R12: instruments on path
    dbg_in = 8'h5C;
    access(0, 1, 1, 1, 8'hA5, 4'h9, 0, "R8 debug access");
    // R10: capture and shift together, then open c0
    dbg_in = 8'h3E;
    access(1, 1, 1, 1, 8'hA5, 4'h9, 1, "R10 capture priority");
    // R7: sensor captured, close c1
    sens_val = 8'hC3;
    access(0, 0, 1, 1, 8'h5A, 4'h6, 0, "R7 sensor read");
    // R6: children gated while c1 closed
    dbg_in = 8'h77;
    access(0, 0, 0, 0, 8'h00, 4'h0, 0, "R6 gated child");
    // R11: strobes with sel low
    @(negedge clk); sel = 0; cap = 1; scan_in = 1;
    @(negedge clk); cap = 0; shf = 1;
    @(negedge clk);
    @(negedge clk); shf = 0; upd = 1;
    @(negedge clk); upd = 0; #1;
    chk(64'(dbg_out), 64'(dbg_e), "R11 dbg_out");
    chk(64'(ctl_out), 64'(ctl_e), "R11 ctl_out");
    access(0, 1, 0, 0, '0, '0, 0, "R11 cells unchanged");
    // R6/R9: nested state retained, control readback
    access(0, 1, 1, 1, 8'h0F, 4'h3, 0, "R9 readback");
    repeat (2) @(negedge clk);
    chk(64'(exp_q.size()), 0, "R5 leftover expected bits");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule